// File: doc/BRIEF.md
# Multi-Key Simultaneous-Press Reset Detector

This block watches a small group of input pins and raises a reset request when every pin of a chosen combination is held low at the same moment. A 2-bit selection picks the combination; one code turns detection off. Each pin first passes through its own glitch filter, which can be enabled or bypassed per pin. With the filter bypassed the request follows the pins almost at once; with it enabled a low level must persist for the filter window before it counts, so a brief accidental press never resets the chip.

The filtered level of every pin is also presented on an output vector, so pins that take part in the key combination remain usable as ordinary inputs. The request output is a registered level that holds for as long as the combination stays low; the downstream reset sequencer is not part of this block.

Top module: `kr_keycombo_rst`

## Requirements
- R1: After reset, `rst_req_o` is 0 and every bit of `pin_level_o` is 1 (idle-high pins).
- R2: With `combo_sel_i` = 0 the request stays 0 whatever the pin levels are.
- R3: With the filter bypassed (`filt_en_i` bit = 0) a pin's level reaches `pin_level_o` one clock later, and the request rises on the second clock edge after all selected pins go low.
- R4: With the filter enabled on a pin, its level changes only after the raw input has differed from it for FILT_LEN consecutive clocks; a low pulse of fewer than FILT_LEN clocks never produces a request, and a held low raises the request on the edge FILT_LEN+1 after it began.
- R5: `combo_sel_i` = 1 selects pins 0 and 1, 2 selects pins 0, 1 and 2, 3 selects pins 0 to 3; unselected pins have no effect on the request.
- R6: The request stays 1 for as long as all selected filtered levels stay low, and falls one edge after any selected filtered level returns high.
- R7: A change of `combo_sel_i` is applied on the next clock edge, and switching to a combination that is not all low never produces a request pulse.
- R8: `pin_level_o` shows the filtered level of every pin regardless of `combo_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Raw pin levels, already synchronous to clk |
| filt_en_i | input | NPINS | Per-pin glitch filter enable |
| combo_sel_i | input | 2 | Key combination select (0 = off) |
| pin_level_o | output | NPINS | Filtered pin levels for general input use |
| rst_req_o | output | 1 | Registered reset request |

## Verification
Every result has a fixed delay from the input that causes it: a bypassed pin shows on `pin_level_o` one edge after it changes and on the request one edge later; a filtered pin needs FILT_LEN edges for its level and FILT_LEN+1 for the request; a selection change affects the request one edge later. The bench drives inputs on the falling clock edge and compares on a later falling edge after exactly the number of rising edges each delay requires, both in directed cases with hand-computed expectations and in a random phase checked every cycle against a cycle-level model built from these delays.

// File: rtl/kr_pkg.sv
package kr_pkg;

  typedef enum logic [1:0] {
    KC_OFF  = 2'd0,
    KC_PAIR = 2'd1,
    KC_TRIO = 2'd2,
    KC_QUAD = 2'd3
  } combo_e;

  // Number of low-index pins taking part in a combination.
  function automatic int unsigned combo_span(input logic [1:0] sel);
    case (combo_e'(sel))
      KC_PAIR: combo_span = 2;
      KC_TRIO: combo_span = 3;
      KC_QUAD: combo_span = 4;
      default: combo_span = 0;
    endcase
  endfunction

endpackage

// File: rtl/kr_pin_filter.sv
module kr_pin_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic en_i,
  output logic level_o
);

  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          level_q;
  logic [CW-1:0] run_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b1;
      run_q   <= '0;
    end else if (!en_i) begin
      level_q <= raw_i;
      run_q   <= '0;
    end else if (raw_i == level_q) begin
      run_q   <= '0;
    end else if (run_q == LAST) begin
      level_q <= raw_i;
      run_q   <= '0;
    end else begin
      run_q   <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  assign level_o = level_q;

  AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !armed_q)
    !$past(en_i) |-> level_o == $past(raw_i)); // R3

  AST_FILTER_MOVES_TO_INPUT: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (en_i && $past(en_i) && level_o != $past(level_o)) |-> level_o == $past(raw_i)); // R4

  initial begin
    assert (FILT_LEN >= 2);
  end

endmodule

// File: rtl/kr_combo_match.sv
module kr_combo_match
  import kr_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] level_i,
  input  logic [1:0]       sel_i,
  output logic             req_o
);

  logic [NPINS-1:0] sel_mask;
  logic             all_low;
  logic             req_q;

  always_comb begin
    sel_mask = '0;
    for (int i = 0; i < NPINS; i++) begin
      sel_mask[i] = (i < int'(combo_span(sel_i)));
    end
  end

  assign all_low = (sel_mask != '0) && ((level_i & sel_mask) == '0);

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= all_low;
  end

  assign req_o = req_q;

  initial begin
    assert (NPINS >= 4);
  end

endmodule

// File: rtl/kr_keycombo_rst.sv
module kr_keycombo_rst
  import kr_pkg::*;
#(
  parameter int NPINS    = 4,
  parameter int FILT_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] filt_en_i,
  input  logic [1:0]       combo_sel_i,
  output logic [NPINS-1:0] pin_level_o,
  output logic             rst_req_o
);

  logic [NPINS-1:0] level_w;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    kr_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .raw_i   (pin_i[g]),
      .en_i    (filt_en_i[g]),
      .level_o (level_w[g])
    );
  end

  kr_combo_match #(.NPINS(NPINS)) u_match (
    .clk     (clk),
    .rst     (rst),
    .level_i (level_w),
    .sel_i   (combo_sel_i),
    .req_o   (rst_req_o)
  );

  assign pin_level_o = level_w;

  // Checking aids: selection mask seen at the ports.
  logic [NPINS-1:0] chk_mask;
  logic             armed_q;

  always_comb begin
    chk_mask = '0;
    for (int i = 0; i < NPINS; i++) chk_mask[i] = (i < int'(combo_span(combo_sel_i)));
  end

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst || !armed_q)
    ($past(combo_sel_i) == 2'd0) |-> !rst_req_o); // R2

  AST_REQ_NEEDS_ALL_LOW: assert property (@(posedge clk) disable iff (rst || !armed_q)
    rst_req_o |-> (($past(pin_level_o) & $past(chk_mask)) == '0)); // R7

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst || !armed_q)
    ($past(combo_sel_i) != 2'd0 && (($past(pin_level_o) & $past(chk_mask)) == '0)) |-> rst_req_o); // R6

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!rst_req_o && pin_level_o == '1)); // R1

endmodule

// File: tb/sim_kr_keycombo_rst.sv
module sim_kr_keycombo_rst;

  localparam int NP = 4;
  localparam int FL = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pin_i;
  logic [NP-1:0] filt_en_i;
  logic [1:0]    combo_sel_i;
  logic [NP-1:0] pin_level_o;
  logic          rst_req_o;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  kr_keycombo_rst #(.NPINS(NP), .FILT_LEN(FL)) u0 (
    .clk(clk), .rst(rst), .pin_i(pin_i), .filt_en_i(filt_en_i),
    .combo_sel_i(combo_sel_i), .pin_level_o(pin_level_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [NP-1:0] mask_of(input logic [1:0] s);
    case (s)
      2'd1:    mask_of = 4'b0011;
      2'd2:    mask_of = 4'b0111;
      2'd3:    mask_of = 4'b1111;
      default: mask_of = 4'b0000;
    endcase
  endfunction

  // Cycle model built from the stated delays.
  logic [NP-1:0] m_lvl;
  int            m_run [NP];
  logic          m_req;

  always @(posedge clk) begin
    if (rst) begin
      m_lvl = '1;
      m_req = 1'b0;
      for (int i = 0; i < NP; i++) m_run[i] = 0;
    end else begin
      m_req = (combo_sel_i != 2'd0) && ((m_lvl & mask_of(combo_sel_i)) == '0);
      for (int i = 0; i < NP; i++) begin
        if (!filt_en_i[i]) begin
          m_lvl[i] = pin_i[i]; m_run[i] = 0;
        end else if (pin_i[i] == m_lvl[i]) begin
          m_run[i] = 0;
        end else if (m_run[i] == FL - 1) begin
          m_lvl[i] = pin_i[i]; m_run[i] = 0;
        end else begin
          m_run[i]++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_high();
    pin_i = '1;
    step(FL + 3);
  endtask

  initial begin
    #(8 * 190000);
    misses++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D2C3B4A));
    rst = 1'b1; pin_i = '1; filt_en_i = '0; combo_sel_i = 2'd0;
    step(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 req", rst_req_o, 0);
    chk("R1 level", pin_level_o, 4'b1111);

    // R2: disabled even with all low
    pin_i = '0; step(4);
    chk("R2 off", rst_req_o, 0);
    // R8: levels visible while off
    pin_i = 4'b1010; step(1);
    chk("R8 level", pin_level_o, 4'b1010);
    chk("R2 off", rst_req_o, 0);

    // R3 latency unfiltered
    combo_sel_i = 2'd1; settle_high();
    pin_i = 4'b1100; step(1);
    chk("R3 level", pin_level_o, 4'b1100);
    chk("R3 req edge1", rst_req_o, 0);
    step(1);
    chk("R3 req edge2", rst_req_o, 1);
    step(5);
    chk("R6 hold", rst_req_o, 1);
    // R6 release
    pin_i = 4'b1101; step(1);
    chk("R6 release edge1", rst_req_o, 1);
    step(1);
    chk("R6 release edge2", rst_req_o, 0);

    // R7 selection changes
    pin_i = 4'b1100; step(3);
    chk("R7 pre", rst_req_o, 1);
    combo_sel_i = 2'd3; step(1);
    chk("R7 to quad", rst_req_o, 0);
    step(3);
    chk("R7 stays low", rst_req_o, 0);
    combo_sel_i = 2'd1; step(1);
    chk("R7 back to pair", rst_req_o, 1);

    // R5 combinations
    combo_sel_i = 2'd2; pin_i = 4'b0100; step(3);
    chk("R5 trio pin2 high", rst_req_o, 0);
    pin_i = 4'b1000; step(2);
    chk("R5 trio pin3 ignored", rst_req_o, 1);
    combo_sel_i = 2'd3; pin_i = 4'b0000; step(2);
    chk("R5 quad all low", rst_req_o, 1);
    pin_i = 4'b1000; step(2);
    chk("R5 quad pin3 high", rst_req_o, 0);

    // R4 filtered pins
    combo_sel_i = 2'd1; filt_en_i = '1; pin_i = '1; step(2 * FL);
    pin_i = 4'b1100; step(FL - 1);
    pin_i = 4'b1111;
    for (int k = 0; k < 2 * FL; k++) begin
      chk("R4 short pulse", rst_req_o, 0);
      step(1);
    end
    chk("R4 level unchanged", pin_level_o, 4'b1111);
    pin_i = 4'b1100;
    step(FL);
    chk("R4 level edge FL", pin_level_o, 4'b1100);
    chk("R4 req edge FL", rst_req_o, 0);
    step(1);
    chk("R4 req edge FL+1", rst_req_o, 1);

    // Random phase against the model
    rst = 1'b1; step(2); rst = 1'b0;
    for (int c = 0; c < 6000; c++) begin
      if (c % 250 == 0) filt_en_i = NP'($urandom);
      if ($urandom % 40 == 0) combo_sel_i = 2'($urandom);
      if ($urandom % 3 == 0) begin
        if ($urandom % 2 == 0) pin_i = pin_i ^ NP'(1 << ($urandom % NP));
        else if ($urandom % 4 == 0) pin_i = NP'($urandom);
        else pin_i = pin_i & ~mask_of(combo_sel_i);
      end
      if ($urandom % 30 == 0) pin_i = '1;
      step(1);
      chk("R5/R6/R7 req model", rst_req_o, m_req);
      chk("R4/R8 level model", pin_level_o, m_lvl);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule